// File: doc/BRIEF.md
# Write-Protected BCD Calendar Clock

This block keeps wall-clock time and a calendar date in packed BCD: seconds, minutes, hours, day of month, month and a two-digit year. A single-cycle pulse at 1 Hz, produced elsewhere from a slow reference oscillator, moves the time forward while the run bit is set. Seconds roll into minutes, minutes into hours, hours into days. The day rolls into the month according to the month's length, and December 31 rolls into January 1 of the next year. Year 99 wraps to 00.

Software reaches the block through a small register port. Time fields and the control register are write-protected. They accept writes only after two key words have been written to two key registers, in a fixed order. Any other key word closes the protection again. Around each counting step the block raises a one-cycle busy window. A write that arrives during that window is discarded and sets a sticky error flag. Reads are registered, so a read that coincides with a counting step returns a field set that is consistent with itself.

Register addresses: 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6 control (bit 0 = run), 7 status, 8 first key, 9 second key.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 0x00, day and month read 0x01, control reads 0, and the block is locked (status bit 2 = 0).
- R2: Writes to time fields (addresses 0 to 5) and control (address 6) take effect only when the block is unlocked. The block unlocks when 0x83E70B13 is written to address 8 and then 0x95A4F1C1 is written to address 9. A wrong second key, or the keys in reverse order, leaves the block locked.
- R3: Writing any value other than the expected key to either key register locks the block again.
- R4: Written values are masked to field widths: seconds and minutes keep 7 bits, hours and day keep 6 bits, month keeps 5 bits, and year keeps 8 bits. Bits above a field's width read as 0.
- R5: Control bit 0 is the run bit. While it is 0, ticks neither change the time nor raise busy.
- R6: Seconds and minutes step in BCD and wrap from 0x59 to 0x00, each carrying into the next field. Hours wrap from 0x23 to 0x00 and carry into the day.
- R7: The day wraps to 0x01 after the month's last day: 30 days for April, June, September and November, 31 days for the other months except February, and 29 days for February when the BCD year is divisible by 4, otherwise 28. Month 0x12 wraps to 0x01 and carries into the year, and year 0x99 wraps to 0x00.
- R8: Busy (the port, and status bit 0) is high for exactly one cycle. That cycle is the one after the clock edge that samples a rising tick while running. The time changes at the clock edge that ends that cycle.
- R9: A write sampled while busy is high is dropped, whatever its address, and sets status bit 1. The bit stays set until a write to address 7 with bit 1 = 1 is accepted. This clearing write is not affected by the lock.
- R10: rdata updates only at a clock edge that samples rd_en, and then holds. A read sampled at the same edge as a counting step returns the value from before the step.
- R11: Status bit 3 reads 1 exactly when the year field is 0x00, which marks a clock whose time has never been set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle 1 Hz counting pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| busy | output | 1 | Update window in progress; writes are dropped |

## Verification
Writes and key words take effect at the same edge that samples them, so the bench drives on falling edges and reads back on the next access. Busy becomes visible one edge after the tick is sampled, and the bench checks it half a cycle later. The advanced time is present after the second edge, and the bench waits for that edge before it reads. rdata is valid after the edge that samples rd_en, and the bench samples it at the following falling edge. Long sweeps across minute, hour, month and year boundaries compare every field after each step with a binary model that the bench keeps itself.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

  localparam int SEC_W = 7;
  localparam int MIN_W = 7;
  localparam int HR_W  = 6;
  localparam int DAY_W = 6;
  localparam int MON_W = 5;
  localparam int YR_W  = 8;
  localparam int NUM_FIELDS = 6;

  localparam logic [3:0] A_SEC  = 4'd0;
  localparam logic [3:0] A_MIN  = 4'd1;
  localparam logic [3:0] A_HR   = 4'd2;
  localparam logic [3:0] A_DAY  = 4'd3;
  localparam logic [3:0] A_MON  = 4'd4;
  localparam logic [3:0] A_YR   = 4'd5;
  localparam logic [3:0] A_CTRL = 4'd6;
  localparam logic [3:0] A_STAT = 4'd7;
  localparam logic [3:0] A_KEYA = 4'd8;
  localparam logic [3:0] A_KEYB = 4'd9;

  typedef struct packed {
    logic [YR_W-1:0]  yr;
    logic [MON_W-1:0] mon;
    logic [DAY_W-1:0] day;
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] mn;
    logic [SEC_W-1:0] sc;
  } rtc_time_t;

  typedef enum logic [1:0] {KG_LOCKED, KG_ARMED, KG_OPEN} kg_state_t;

  // next value of a two-digit BCD number (no wrap handling)
  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic leap_year(input logic [7:0] y);
    logic [6:0] b;
    b = bcd_bin(y);
    return (b[1:0] == 2'b00);
  endfunction

  // last day of a month, in BCD
  function automatic logic [DAY_W-1:0] month_len(input logic [MON_W-1:0] m,
                                                 input logic [YR_W-1:0] y);
    case (m)
      5'h02:                      return leap_year(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  // one second forward with the full carry chain
  function automatic rtc_time_t time_step(input rtc_time_t t);
    rtc_time_t n;
    n = t;
    if (t.sc != 7'h59) begin
      n.sc = 7'(bcd_next(8'(t.sc)));
    end else begin
      n.sc = '0;
      if (t.mn != 7'h59) begin
        n.mn = 7'(bcd_next(8'(t.mn)));
      end else begin
        n.mn = '0;
        if (t.hr != 6'h23) begin
          n.hr = 6'(bcd_next(8'(t.hr)));
        end else begin
          n.hr = '0;
          if (t.day < month_len(t.mon, t.yr)) begin
            n.day = 6'(bcd_next(8'(t.day)));
          end else begin
            n.day = 6'h01;
            if (t.mon < 5'h12) begin
              n.mon = 5'(bcd_next(8'(t.mon)));
            end else begin
              n.mon = 5'h01;
              n.yr  = (t.yr == 8'h99) ? 8'h00 : bcd_next(t.yr);
            end
          end
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_key_guard.sv
module rtc_key_guard #(
  parameter int          KEY_W = 32,
  parameter logic [31:0] KEY_A = 32'h83E70B13,
  parameter logic [31:0] KEY_B = 32'h95A4F1C1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ka_wr,
  input  logic             kb_wr,
  input  logic [KEY_W-1:0] key_data,
  output logic             is_open
);
  import bcd_rtc_pkg::*;

  kg_state_t state_q, state_d;
  logic ka_match, kb_match;

  assign ka_match = (key_data == KEY_W'(KEY_A));
  assign kb_match = (key_data == KEY_W'(KEY_B));

  always_comb begin
    state_d = state_q;
    if (ka_wr)      state_d = ka_match ? KG_ARMED : KG_LOCKED;
    else if (kb_wr) state_d = (kb_match && state_q == KG_ARMED) ? KG_OPEN : KG_LOCKED;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= KG_LOCKED;
    else        state_q <= state_d;
  end

  assign is_open = (state_q == KG_OPEN);

  // R2: opening needs a correct second key right after an armed state
  assert_open_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_open) |-> $past(kb_wr && kb_match && state_q == KG_ARMED));

  // R3: a mismatching key leaves the guard closed
  assert_bad_key_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ka_wr && !ka_match) || (kb_wr && !kb_match)) |=> !is_open);

endmodule

// File: rtl/rtc_tick_sync.sv
module rtc_tick_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic run,
  output logic busy
);
  logic tick_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_d <= 1'b0;
      busy   <= 1'b0;
    end else begin
      tick_d <= tick_in;
      busy   <= tick_in && !tick_d && run;
    end
  end

  // R8: busy never lasts two cycles
  assert_busy_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // R5: busy only follows a cycle with run set
  assert_busy_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $past(run));

endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import bcd_rtc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  advance,
  input  logic [NUM_FIELDS-1:0] ld_en,
  input  logic [7:0]            ld_data,
  output rtc_time_t             now
);

  rtc_time_t stepped;
  assign stepped = time_step(now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now     <= '0;
      now.day <= 6'h01;
      now.mon <= 5'h01;
    end else if (advance) begin
      now <= stepped;
    end else begin
      if (ld_en[0]) now.sc  <= ld_data[SEC_W-1:0];
      if (ld_en[1]) now.mn  <= ld_data[MIN_W-1:0];
      if (ld_en[2]) now.hr  <= ld_data[HR_W-1:0];
      if (ld_en[3]) now.day <= ld_data[DAY_W-1:0];
      if (ld_en[4]) now.mon <= ld_data[MON_W-1:0];
      if (ld_en[5]) now.yr  <= ld_data[YR_W-1:0];
    end
  end

  // R6: seconds wrap at 59 and carry into minutes
  assert_sec_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && now.sc == 7'h59) |=> (now.sc == 7'h00));

  // R7: year 99 at the end of December 31 23:59:59 wraps to 00
  assert_year_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && now.yr == 8'h99 && now.mon == 5'h12 && now.day == 6'h31 &&
     now.hr == 6'h23 && now.mn == 7'h59 && now.sc == 7'h59) |=>
    (now.yr == 8'h00 && now.mon == 5'h01 && now.day == 6'h01));

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter int          DATA_W = 32,
  parameter int          ADDR_W = 4,
  parameter logic [31:0] KEY_A  = 32'h83E70B13,
  parameter logic [31:0] KEY_B  = 32'h95A4F1C1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy
);
  import bcd_rtc_pkg::*;

  logic                  wr_ok, wr_drop, unlocked, run_q, wr_err_q, cold;
  logic                  err_clear;
  logic [NUM_FIELDS-1:0] ld_en;
  logic [DATA_W-1:0]     rd_value;
  rtc_time_t             now;

  assign wr_ok     = wr_en && !busy;
  assign wr_drop   = wr_en && busy;
  assign err_clear = wr_ok && (addr == ADDR_W'(A_STAT)) && wdata[1];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_ld
      assign ld_en[gi] = wr_ok && unlocked && (addr == ADDR_W'(gi));
    end
  endgenerate

  rtc_key_guard #(.KEY_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .ka_wr    (wr_ok && addr == ADDR_W'(A_KEYA)),
    .kb_wr    (wr_ok && addr == ADDR_W'(A_KEYB)),
    .key_data (wdata),
    .is_open  (unlocked)
  );

  rtc_tick_sync u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_in (tick_1hz),
    .run     (run_q),
    .busy    (busy)
  );

  rtc_time_counter u_time (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (busy),
    .ld_en   (ld_en),
    .ld_data (wdata[7:0]),
    .now     (now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      wr_err_q <= 1'b0;
    end else begin
      if (wr_ok && unlocked && addr == ADDR_W'(A_CTRL)) run_q <= wdata[0];
      if (wr_drop)        wr_err_q <= 1'b1;
      else if (err_clear) wr_err_q <= 1'b0;
    end
  end

  assign cold = (now.yr == '0);

  always_comb begin
    rd_value = '0;
    case (addr)
      ADDR_W'(A_SEC):  rd_value = DATA_W'(now.sc);
      ADDR_W'(A_MIN):  rd_value = DATA_W'(now.mn);
      ADDR_W'(A_HR):   rd_value = DATA_W'(now.hr);
      ADDR_W'(A_DAY):  rd_value = DATA_W'(now.day);
      ADDR_W'(A_MON):  rd_value = DATA_W'(now.mon);
      ADDR_W'(A_YR):   rd_value = DATA_W'(now.yr);
      ADDR_W'(A_CTRL): rd_value = DATA_W'(run_q);
      ADDR_W'(A_STAT): rd_value = DATA_W'({cold, unlocked, wr_err_q, busy});
      default:         rd_value = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_value;
  end

  // R2: locked and not updating -> time does not move
  assert_locked_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !busy) |=> $stable(now));

  // R9: a write during busy raises the error flag
  assert_drop_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> wr_err_q);

  // R9: the flag is sticky until cleared
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err_q && !(wr_en && !busy && addr == ADDR_W'(A_STAT) && wdata[1])) |=> wr_err_q);

  // R10: read data holds without a read strobe
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: tb/test_bcd_rtc_core.sv
module test_bcd_rtc_core;
  localparam logic [31:0] K1 = 32'h83E70B13;
  localparam logic [31:0] K2 = 32'h95A4F1C1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busy;

  int checks = 0;
  int errors = 0;
  int m_y, m_mo, m_d, m_h, m_mi, m_s;
  logic [31:0] v, old;

  always #5 clk = ~clk;

  bcd_rtc_core i_bcd_rtc_core (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  function automatic logic [31:0] to_bcd(input int n);
    return 32'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic tick_once();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(4'd8, K1); wr(4'd9, K2);
  endtask

  task automatic set_model(input int y, input int mo, input int d, input int h,
                           input int mi, input int s);
    m_y = y; m_mo = mo; m_d = d; m_h = h; m_mi = mi; m_s = s;
    wr(4'd0, to_bcd(s)); wr(4'd1, to_bcd(mi)); wr(4'd2, to_bcd(h));
    wr(4'd3, to_bcd(d)); wr(4'd4, to_bcd(mo)); wr(4'd5, to_bcd(y));
  endtask

  task automatic model_step();
    m_s++;
    if (m_s == 60) begin m_s = 0; m_mi++; end
    if (m_mi == 60) begin m_mi = 0; m_h++; end
    if (m_h == 24) begin m_h = 0; m_d++; end
    if (m_d > mdays(m_mo, m_y)) begin m_d = 1; m_mo++; end
    if (m_mo == 13) begin m_mo = 1; m_y = (m_y + 1) % 100; end
  endtask

  task automatic cmp_time(input string tag);
    logic [31:0] r;
    rd(4'd0, r); chk({tag, " sec"}, r, to_bcd(m_s));
    rd(4'd1, r); chk({tag, " min"}, r, to_bcd(m_mi));
    rd(4'd2, r); chk({tag, " hour"}, r, to_bcd(m_h));
    rd(4'd3, r); chk({tag, " day"}, r, to_bcd(m_d));
    rd(4'd4, r); chk({tag, " month"}, r, to_bcd(m_mo));
    rd(4'd5, r); chk({tag, " year"}, r, to_bcd(m_y));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values, R11 cold flag
    m_y = 0; m_mo = 1; m_d = 1; m_h = 0; m_mi = 0; m_s = 0;
    cmp_time("R1 reset");
    rd(4'd6, v); chk("R1 run after reset", v, 32'h0);
    rd(4'd7, v); chk("R1 status after reset (R11 cold)", v, 32'h8);
    chk("R1 busy after reset", 32'(busy), 32'h0);

    // R2 locked writes ignored
    wr(4'd0, 32'h12); rd(4'd0, v); chk("R2 locked write", v, 32'h0);
    wr(4'd6, 32'h1);  rd(4'd6, v); chk("R2 locked ctrl", v, 32'h0);
    wr(4'd8, K1); wr(4'd9, 32'h12345678);
    rd(4'd7, v); chk("R2 wrong second key", v & 32'h4, 32'h0);
    wr(4'd0, 32'h12); rd(4'd0, v); chk("R2 wrong key write", v, 32'h0);
    wr(4'd9, K2); wr(4'd8, K1);
    rd(4'd7, v); chk("R2 reversed keys", v & 32'h4, 32'h0);
    wr(4'd0, 32'h12); rd(4'd0, v); chk("R2 reversed key write", v, 32'h0);
    unlock();
    rd(4'd7, v); chk("R2 unlocked status", v & 32'h4, 32'h4);
    wr(4'd0, 32'h12); rd(4'd0, v); chk("R2 unlocked write", v, 32'h12);

    // R4 field masks
    wr(4'd0, 32'hFFFF); rd(4'd0, v); chk("R4 sec mask", v, 32'h7F);
    wr(4'd1, 32'hFFFF); rd(4'd1, v); chk("R4 min mask", v, 32'h7F);
    wr(4'd2, 32'hFFFF); rd(4'd2, v); chk("R4 hour mask", v, 32'h3F);
    wr(4'd3, 32'hFFFF); rd(4'd3, v); chk("R4 day mask", v, 32'h3F);
    wr(4'd4, 32'hFFFF); rd(4'd4, v); chk("R4 month mask", v, 32'h1F);
    wr(4'd5, 32'hFFFF); rd(4'd5, v); chk("R4 year mask", v, 32'hFF);

    // R3 relock through either key register
    wr(4'd8, 32'h0);
    rd(4'd7, v); chk("R3 relock via first key", v & 32'h4, 32'h0);
    wr(4'd0, 32'h05); rd(4'd0, v); chk("R3 locked after relock", v, 32'h7F);
    unlock(); wr(4'd9, 32'hDEADBEEF);
    rd(4'd7, v); chk("R3 relock via second key", v & 32'h4, 32'h0);
    unlock();

    // R5 stopped clock ignores ticks; R11 cold flag clears
    set_model(24, 6, 15, 10, 20, 30);
    rd(4'd7, v); chk("R11 cold flag clear", v & 32'h8, 32'h0);
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    chk("R5 no busy when stopped", 32'(busy), 32'h0);
    @(negedge clk);
    cmp_time("R5 frozen");
    wr(4'd6, 32'h1); rd(4'd6, v); chk("R5 run set", v, 32'h1);

    // R8 busy timing and step at the end of the busy cycle
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    chk("R8 busy high", 32'(busy), 32'h1);
    @(negedge clk);
    chk("R8 busy one cycle", 32'(busy), 32'h0);
    model_step(); cmp_time("R8 step");

    // R9 write during busy is dropped and flagged
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0; wr_en = 1'b1; addr = 4'd0; wdata = 32'h44;
    @(negedge clk); wr_en = 1'b0;
    model_step();
    rd(4'd0, v); chk("R9 dropped write", v, to_bcd(m_s));
    rd(4'd7, v); chk("R9 error flag set", v & 32'h2, 32'h2);
    repeat (3) @(negedge clk);
    rd(4'd7, v); chk("R9 error flag sticky", v & 32'h2, 32'h2);
    wr(4'd8, 32'h0);
    wr(4'd7, 32'h2);
    rd(4'd7, v); chk("R9 error clear while locked", v & 32'h6, 32'h0);
    unlock();

    // R10 read hold and read at the step edge
    rd(4'd0, old);
    tick_once(); model_step();
    chk("R10 rdata holds", rdata, old);
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0; rd_en = 1'b1; addr = 4'd0;
    @(negedge clk); rd_en = 1'b0;
    chk("R10 read at step edge", rdata, to_bcd(m_s));
    model_step();
    rd(4'd0, v); chk("R10 read after step", v, to_bcd(m_s));

    // R7 month-end sweep over leap and common years
    foreach (m_y_list[yi]) begin
      for (int mo = 1; mo <= 12; mo++) begin
        set_model(m_y_list[yi], mo, mdays(mo, m_y_list[yi]), 23, 59, 59);
        tick_once(); model_step();
        cmp_time("R7 month end");
      end
    end

    // R6/R7/R11 year wrap sweep
    set_model(99, 12, 31, 23, 58, 0);
    for (int i = 0; i < 130; i++) begin
      tick_once(); model_step();
      cmp_time("R6 R7 year wrap sweep");
    end
    rd(4'd7, v); chk("R11 cold after wrap", v & 32'h8, 32'h8);

    // R6 long sweep across minutes and hours
    set_model(24, 2, 28, 22, 59, 0);
    for (int i = 0; i < 3700; i++) begin
      tick_once(); model_step();
      cmp_time("R6 long sweep");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  int m_y_list[3] = '{23, 24, 0};

endmodule